// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

This block is a synchronous single-port memory whose command port accepts a read, a write or an idle slot on every rising clock edge. Reads and writes can alternate freely with no idle cycle between them. The address and command are registered on the edge that issues them. Write data arrives on the shared data input two edges later. Read data leaves through an output register one edge after the command and is visible in the cycle after that. Per-byte write masks, a four-beat burst counter with linear or exclusive-or ordering, a clock-enable stall and a sleep input complete the port.

A read that targets a word whose write is still waiting for its data returns the merged value. Lanes being written come from the live data input, and the remaining lanes come from the array. The tri-stated data pins of a board-level part are modelled as a registered read bus, `rdata`, and a separate drive-enable, `rdata_oe`.

The port is decoded edge by edge rather than through a valid/ready handshake, because every cycle carries a fixed-latency slot. The only back-pressure is `clk_en_n`. While it is high, the slot is frozen, the caller must hold its data, and nothing in the block moves.

Top module: `zt_sram`

## Requirements
- R1: A new access starts at a rising edge only when `clk_en_n`=0, `adv_ld`=0 and the chip is selected (`sel1_n`=0, `sel2`=1, `sel3_n`=0). `wr_n`=0 makes it a write and `wr_n`=1 makes it a read.
- R2: An edge with `clk_en_n`=1 changes nothing. Pipeline stages, the burst position, `rdata` and the drive state are all held, and no write is committed.
- R3: For a write issued at edge n, `rdata_oe` is 0 after edge n+1. `wdata` is sampled at edge n+2 and committed at that edge.
- R4: For a read issued at edge n, the addressed word is loaded into `rdata` at edge n+1. `rdata_oe` equals `!oe_n` in the cycle that follows.
- R5: `lane_n[k]` is active low and enables bits [8k+7:8k] of a write. It is sampled on the edge that issues the write beat. Unselected lanes keep their contents, and a write with `lane_n`=4'b1111 changes nothing.
- R6: Apart from the forced-off cases in R3, R7, R9 and R10, `rdata_oe` follows `!oe_n` combinationally.
- R7: An edge that sees `adv_ld`=0 without a full chip select is a deselect. It ends any burst, and `rdata_oe` is 0 after the following active edge. The first cycle of a read issued after a deselect is also off.
- R8: With `adv_ld`=1, the chip selects and `wr_n` are ignored. The current burst advances one beat and keeps the type latched at its start. Beat k (k=0..3, wrapping after 3) uses low address bits base+k mod 4 when `burst_ilv`=0, or base XOR k when `burst_ilv`=1. The upper bits stay fixed. With no burst open, `adv_ld`=1 issues nothing.
- R9: After `sleep` has been high for two edges, the block is asleep. It stays asleep until `sleep` has been low for two edges. While asleep, pending accesses are dropped, commands are ignored, `rdata_oe` is 0 and array contents are kept. Outputs stay off after waking until a new read arrives.
- R10: During and after reset, the block is deselected with `rdata_oe`=0.
- R11: A read at the edge where an earlier write to the same address commits returns the written lanes from `wdata` and the other lanes from the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low edge qualifier; high stalls everything |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 loads a new command, 1 advances the burst |
| wr_n | input | 1 | 0 write, 1 read, latched at burst start |
| lane_n | input | LANES | Active-low byte-lane write enables |
| addr | input | AW | Word address |
| burst_ilv | input | 1 | 0 linear burst order, 1 exclusive-or order |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Request for the low-power state |
| wdata | input | LANES*LW | Write data, sampled two edges after its command |
| rdata | output | LANES*LW | Registered read data |
| rdata_oe | output | 1 | Data drive-enable |

## Verification
The bench keeps the default build: 64 words of four 8-bit lanes. At that depth the whole array can be written first, so every later read is compared against a known word. Random addresses then collide often enough to produce read-after-pending-write merges, burst wrap within a four-word group, and stalls landing between an address and its data. Both burst orders and every lane mask occur.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_XOR = 1'b1} burst_ord_e;

  function automatic logic [1:0] beat_lo(input logic [1:0] base,
                                         input logic [1:0] step,
                                         input burst_ord_e ord);
    return (ord == ORD_XOR) ? (base ^ step) : (base + step);
  endfunction
endpackage

// File: rtl/zt_issue.sv
module zt_issue
  import zt_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             flush,
  input  logic             adv_ld,
  input  logic             sel_ok,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_n,
  input  logic [AW-1:0]    addr,
  input  logic             burst_ilv,
  output logic             iss_vld,
  output logic             iss_wr,
  output logic [AW-1:0]    iss_addr,
  output logic [LANES-1:0] iss_lanes
);
  logic          b_act, b_wr;
  logic [AW-1:0] b_base;
  logic [1:0]    b_cnt;
  logic [1:0]    nxt_cnt;

  assign nxt_cnt   = b_cnt + 2'd1;
  assign iss_lanes = ~lane_n;

  always_comb begin
    if (!adv_ld) begin
      iss_vld  = step_en & sel_ok;
      iss_wr   = ~wr_n;
      iss_addr = addr;
    end else begin
      iss_vld  = step_en & b_act;
      iss_wr   = b_wr;
      iss_addr = {b_base[AW-1:2], beat_lo(b_base[1:0], nxt_cnt, burst_ord_e'(burst_ilv))};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_act  <= 1'b0;
      b_wr   <= 1'b0;
      b_base <= '0;
      b_cnt  <= '0;
    end else if (flush) begin
      b_act <= 1'b0;
    end else if (step_en) begin
      if (!adv_ld) begin
        b_act  <= sel_ok;
        b_wr   <= ~wr_n;
        b_base <= addr;
        b_cnt  <= '0;
      end else if (b_act) begin
        b_cnt <= nxt_cnt;
      end
    end
  end
endmodule

// File: rtl/zt_array.sv
module zt_array #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                we,
  input  logic [LANES-1:0]    we_lanes,
  input  logic [AW-1:0]       waddr,
  input  logic [LANES*LW-1:0] wdata,
  input  logic [AW-1:0]       raddr,
  output logic [LANES*LW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [LW-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (we && we_lanes[k]) cells[waddr] <= wdata[k*LW +: LW];
    end
    assign rdata[k*LW +: LW] = cells[raddr];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clk_en_n,
  input  logic                sel1_n,
  input  logic                sel2,
  input  logic                sel3_n,
  input  logic                adv_ld,
  input  logic                wr_n,
  input  logic [LANES-1:0]    lane_n,
  input  logic [AW-1:0]       addr,
  input  logic                burst_ilv,
  input  logic                oe_n,
  input  logic                sleep,
  input  logic [LANES*LW-1:0] wdata,
  output logic [LANES*LW-1:0] rdata,
  output logic                rdata_oe
);
  localparam int DW = LANES * LW;

  logic             ce, sel_ok, asleep, step_en, commit;
  logic [1:0]       slp_q;
  logic             iss_vld, iss_wr;
  logic [AW-1:0]    iss_addr;
  logic [LANES-1:0] iss_lanes;
  logic             s1_vld, s1_wr, s2_vld, s2_wr;
  logic [AW-1:0]    s1_addr, s2_addr;
  logic [LANES-1:0] s1_lanes, s2_lanes;
  logic [DW-1:0]    arr_q, merged, rdata_q;
  logic             out_vld;

  assign ce      = ~clk_en_n;
  assign sel_ok  = ~sel1_n & sel2 & ~sel3_n;
  assign asleep  = slp_q[1];
  assign step_en = ce & ~asleep;
  assign commit  = step_en & s2_vld & s2_wr;

  zt_issue #(.AW(AW), .LANES(LANES)) u_issue (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .flush(asleep),
    .adv_ld(adv_ld), .sel_ok(sel_ok), .wr_n(wr_n), .lane_n(lane_n),
    .addr(addr), .burst_ilv(burst_ilv),
    .iss_vld(iss_vld), .iss_wr(iss_wr), .iss_addr(iss_addr), .iss_lanes(iss_lanes)
  );

  zt_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
    .clk(clk), .we(commit), .we_lanes(s2_lanes), .waddr(s2_addr),
    .wdata(wdata), .raddr(s1_addr), .rdata(arr_q)
  );

  // Forward lanes of the write committing at this very edge.
  for (genvar k = 0; k < LANES; k++) begin : g_fwd
    logic hit;
    assign hit = s2_vld & s2_wr & s2_lanes[k] & (s2_addr == s1_addr);
    assign merged[k*LW +: LW] = hit ? wdata[k*LW +: LW] : arr_q[k*LW +: LW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slp_q    <= '0;
      s1_vld   <= 1'b0;
      s1_wr    <= 1'b0;
      s1_addr  <= '0;
      s1_lanes <= '0;
      s2_vld   <= 1'b0;
      s2_wr    <= 1'b0;
      s2_addr  <= '0;
      s2_lanes <= '0;
      out_vld  <= 1'b0;
      rdata_q  <= '0;
    end else begin
      slp_q <= {slp_q[0], sleep};
      if (asleep) begin
        s1_vld  <= 1'b0;
        s2_vld  <= 1'b0;
        out_vld <= 1'b0;
      end else if (ce) begin
        s1_vld   <= iss_vld;
        s1_wr    <= iss_wr;
        s1_addr  <= iss_addr;
        s1_lanes <= iss_lanes;
        s2_vld   <= s1_vld;
        s2_wr    <= s1_wr;
        s2_addr  <= s1_addr;
        s2_lanes <= s1_lanes;
        out_vld  <= s1_vld & ~s1_wr;
        if (s1_vld && !s1_wr) rdata_q <= merged;
      end
    end
  end

  assign rdata    = rdata_q;
  assign rdata_oe = out_vld & ~oe_n & ~asleep;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          sel1_n,
  input logic          sel2,
  input logic          sel3_n,
  input logic          adv_ld,
  input logic          wr_n,
  input logic          oe_n,
  input logic          asleep,
  input logic [DW-1:0] rdata,
  input logic          rdata_oe
);
  logic sel;
  assign sel = ~sel1_n & sel2 & ~sel3_n;

  always @(posedge clk) begin
    if (!rst_n) p_reset_quiet_r10: assert (!rdata_oe);
  end

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable(rdata));

  p_write_phase_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && sel && !wr_n && !asleep) ##1 !clk_en_n |=> !rdata_oe);

  p_read_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && sel && wr_n && !asleep) ##1 (!clk_en_n && !asleep)
    |=> (asleep || (rdata_oe == !oe_n)));

  p_oe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> !oe_n);

  p_deselect_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && !sel) ##1 !clk_en_n |=> !rdata_oe);

  p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !rdata_oe);
endmodule

bind zt_sram zt_sram_chk #(.DW(LANES*LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
  .sel3_n(sel3_n), .adv_ld(adv_ld), .wr_n(wr_n), .oe_n(oe_n), .asleep(asleep),
  .rdata(rdata), .rdata_oe(rdata_oe)
);

// File: tb/test_zt_sram.sv
module test_zt_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en_n = 1'b1, sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
  logic        adv_ld = 1'b0, wr_n = 1'b1, burst_ilv = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic [3:0]  lane_n = 4'hF;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rdata_oe;

  always #5 clk = ~clk;

  zt_sram i_zt_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .adv_ld(adv_ld), .wr_n(wr_n), .lane_n(lane_n), .addr(addr),
    .burst_ilv(burst_ilv), .oe_n(oe_n), .sleep(sleep), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int    checks = 0, errors = 0;
  string tag = "R10";
  bit    done = 1'b0;

  task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // ---------------- behavioural reference ----------------
  typedef struct { bit v; bit w; int a; bit [3:0] ln; } op_t;
  op_t         q[$];
  logic [31:0] ref_mem [64];
  bit          b_act, b_wr, exp_vld, m_sl0, m_sl1;
  int          b_base, b_cnt;
  logic [31:0] exp_data;

  function automatic op_t mk(bit v, bit w, int a, bit [3:0] ln);
    op_t o;
    o.v = v; o.w = w; o.a = a; o.ln = ln;
    return o;
  endfunction

  always @(posedge clk) begin : model
    op_t o_new;
    int  lo;
    if (!rst_n) begin
      q = {}; q.push_back(mk(0,0,0,0)); q.push_back(mk(0,0,0,0));
      b_act = 0; exp_vld = 0; m_sl0 = 0; m_sl1 = 0; exp_data = '0;
    end else begin
      if (m_sl1) begin
        q = {}; q.push_back(mk(0,0,0,0)); q.push_back(mk(0,0,0,0));
        b_act = 0; exp_vld = 0;
      end else if (!clk_en_n) begin
        if (q[0].v && q[0].w)
          for (int k = 0; k < 4; k++) if (q[0].ln[k]) ref_mem[q[0].a][k*8 +: 8] = wdata[k*8 +: 8];
        if (q[1].v && !q[1].w) begin exp_data = ref_mem[q[1].a]; exp_vld = 1; end
        else exp_vld = 0;
        if (!adv_ld) begin
          if (!sel1_n && sel2 && !sel3_n) begin
            b_act = 1; b_base = int'(addr); b_cnt = 0; b_wr = !wr_n;
            o_new = mk(1, !wr_n, int'(addr), ~lane_n);
          end else begin b_act = 0; o_new = mk(0,0,0,0); end
        end else if (b_act) begin
          b_cnt = (b_cnt + 1) % 4;
          lo = burst_ilv ? ((b_base % 4) ^ b_cnt) : ((b_base % 4 + b_cnt) % 4);
          o_new = mk(1, b_wr, (b_base / 4) * 4 + lo, ~lane_n);
        end else o_new = mk(0,0,0,0);
        void'(q.pop_front());
        q.push_back(o_new);
      end
      m_sl1 = m_sl0;
      m_sl0 = sleep;
    end
  end

  always @(negedge clk) begin : compare
    bit exp_oe;
    if (!rst_n) chk(rdata_oe == 1'b0, "R10", {31'd0, rdata_oe}, 32'd0);
    else begin
      exp_oe = exp_vld && !oe_n && !m_sl1;
      chk(rdata_oe == exp_oe, tag, {31'd0, rdata_oe}, {31'd0, exp_oe});
      if (exp_oe) chk(rdata == exp_data, tag, rdata, exp_data);
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input bit cen_n, input bit cs, input bit adv, input bit wn,
                     input logic [3:0] ln, input logic [5:0] a);
    @(posedge clk); #1;
    clk_en_n = cen_n; adv_ld = adv; wr_n = wn; lane_n = ln; addr = a;
    wdata = $urandom;
    if (cs) begin sel1_n = 0; sel2 = 1; sel3_n = 0; end
    else case ($urandom % 3)
      0: begin sel1_n = 1; sel2 = 1; sel3_n = 0; end
      1: begin sel1_n = 0; sel2 = 0; sel3_n = 0; end
      default: begin sel1_n = 0; sel2 = 1; sel3_n = 1; end
    endcase
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 4'hF, 0);
  endtask

  initial begin : watchdog
    #(150000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tag = "R10"; idle(2);

    // R1/R3: fill the array with linear write bursts
    tag = "R1"; burst_ilv = 0;
    for (int b = 0; b < 16; b++) begin
      cyc(0, 1, 0, 0, 4'h0, 6'(b * 4));
      for (int j = 0; j < 3; j++) cyc(0, $urandom % 2, 1, $urandom % 2, 4'h0, 6'($urandom));
    end
    idle(2);

    // R4: single reads, then read/write interleave (R3)
    tag = "R4";
    for (int i = 0; i < 8; i++) cyc(0, 1, 0, 1, 4'hF, 6'(i * 7));
    tag = "R3";
    for (int i = 0; i < 12; i++) cyc(0, 1, 0, i % 2, 4'h0, 6'(i * 5));
    idle(2);

    // R8: bursts in both orders, beyond four beats, selects ignored
    tag = "R8";
    for (int m = 0; m < 2; m++) begin
      burst_ilv = m[0];
      for (int s = 0; s < 4; s++) begin
        cyc(0, 1, 0, 1, 4'hF, 6'(16 + s));
        for (int j = 0; j < 5; j++) cyc(0, $urandom % 2, 1, 0, 4'h0, 6'($urandom));
      end
    end
    burst_ilv = 1;
    cyc(0, 1, 0, 0, 4'h0, 6'd42);
    for (int j = 0; j < 3; j++) cyc(0, 0, 1, 1, 4'h0, 0);
    cyc(0, 0, 1, 1, 4'hF, 0);
    cyc(0, 1, 0, 1, 4'hF, 6'd40);
    for (int j = 0; j < 3; j++) cyc(0, 1, 1, 0, 4'hF, 0);
    idle(2);

    // R5: lane masks, including none selected
    tag = "R5";
    for (int ln = 0; ln < 16; ln++) begin
      cyc(0, 1, 0, 0, 4'(ln), 6'(ln));
      cyc(0, 1, 0, 1, 4'hF, 6'(30));
    end
    for (int ln = 0; ln < 16; ln++) cyc(0, 1, 0, 1, 4'hF, 6'(ln));
    idle(2);

    // R11: read immediately after a partial write to the same word
    tag = "R11";
    for (int i = 0; i < 10; i++) begin
      cyc(0, 1, 0, 0, 4'($urandom), 6'(50 + i % 3));
      cyc(0, 1, 0, 1, 4'hF, 6'(50 + i % 3));
      cyc(0, 1, 0, 1, 4'hF, 6'(50 + i % 3));
    end
    idle(2);

    // R2: stalls between address and data
    tag = "R2";
    for (int i = 0; i < 60; i++)
      cyc(($urandom % 2), 1, 0, $urandom % 2, 4'($urandom), 6'($urandom % 8));
    idle(2);

    // R7: deselects between reads
    tag = "R7";
    for (int i = 0; i < 20; i++) begin
      cyc(0, 1, 0, 1, 4'hF, 6'($urandom));
      cyc(0, 0, 0, 1, 4'hF, 0);
      if (i % 2) cyc(0, 0, 1, 1, 4'hF, 0);
    end

    // R6: output enable toggling, mixed traffic
    tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      oe_n = ($urandom % 6 == 0);
      burst_ilv = $urandom % 2;
      cyc(($urandom % 5 == 0), ($urandom % 8 != 0), ($urandom % 3 == 0),
          $urandom % 2, 4'($urandom), 6'($urandom % 16));
    end
    oe_n = 0;
    idle(2);

    // R9: sleep with contents kept, commands ignored while asleep
    tag = "R9";
    idle(1);
    sleep = 1;
    idle(2);
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, i % 2, 4'h0, 6'(i));
    sleep = 0;
    idle(3);
    for (int i = 0; i < 16; i++) cyc(0, 1, 0, 1, 4'hF, 6'(i));
    idle(3);

    finish_run();
  end
endmodule